// File: doc/BRIEF.md
# Six-Channel DMA Burst Arbiter

This block decides which of six DMA channels owns the transfer datapath for its next burst. A channel is eligible when both its enable and its pending-request inputs are high. The datapath reports the end of each read-write word and the end of each burst, and the arbiter answers with a one-hot grant, a 3-bit code for the active channel and a 3-bit shadow code.

In the default mode all channels take turns in circular order. The optional high-priority mode takes channel 1 out of the rotation. In that mode channel 1 interrupts a running low-priority burst at the next word boundary. The interrupted channel is parked in the shadow code and resumes when channel 1 finishes.

Three control inputs act on the arbiter:
- A priority-reset pulse restarts the rotation, but only once the relevant bursts have drained.
- A hard-reset pulse clears everything one clock after it arrives.
- A debug halt freezes granting at a word boundary, unless the free-run input is set.

Top module: `dma_prio_arbiter`

## Requirements
- R1: `active_code` is 0 when no channel is active and n (1 to 6) when channel n owns the datapath. The value 7 never appears. `grant` bit n-1 is high only for the active channel, and `grant` is all zero when idle. After reset, `grant`, `active_code`, `shadow_code` and `hi_prio_mode` are all 0.
- R2: In default mode, an idle arbiter picks the first eligible channel (`ch_enable & ch_request`). The search is circular and starts at the channel after the last one picked through rotation. After reset the search starts at channel 1.
- R3: A grant is held for a whole burst. Request changes and `word_done` do not move it. After a `burst_done` edge `active_code` is 0 for one cycle, and the next pick appears after the following edge.
- R4: A `prio_reset` pulse during a burst has no effect until that burst ends. The rotation then restarts: from channel 1 in default mode, from channel 2 in high-priority mode.
- R5: In high-priority mode, channel 1 wins every idle arbitration in which it is eligible. Channel 1 is never chosen by the rotation.
- R6: In high-priority mode, when channel 1 becomes eligible during another channel's burst, the takeover happens only on a `word_done` cycle that is not also a `burst_done` cycle. At that edge `shadow_code` takes the old active code and `active_code` becomes 1.
- R7: When a channel 1 burst ends in high-priority mode, `active_code` takes `shadow_code`. The interrupted channel therefore resumes, with the shadow equal to the active code. If channel 1 started from idle, the arbiter goes idle. The end of any other burst clears `shadow_code` to 0.
- R8: In high-priority mode, a `prio_reset` during a channel 1 burst is deferred past that burst and past the next low-priority burst. Only then does the rotation restart from channel 2.
- R9: A `cfg_wr` pulse loads `cfg_hi_prio` into `hi_prio_mode` only when all six enables are low. In any other case it is ignored.
- R10: A `hard_reset` pulse has no visible effect after the first edge. The second edge clears the grant, both codes and the mode, and returns the rotation to channel 1.
- R11: With `halt_req` high and `free_run` low, a running burst keeps its grant until the next `word_done`. After that edge `grant` is 0 while `active_code` keeps the channel. An idle arbiter grants nothing. Clearing `halt_req` restores the grant one edge later.
- R12: With `free_run` high, `halt_req` has no effect on granting.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| ch_enable | input | 6 | Per-channel enable, bit n-1 for channel n |
| ch_request | input | 6 | Per-channel pending burst request |
| word_done | input | 1 | Current read-write word completed |
| burst_done | input | 1 | Current burst completed |
| cfg_wr | input | 1 | Pulse: load the priority mode |
| cfg_hi_prio | input | 1 | Mode value loaded by `cfg_wr` (1 = channel 1 preempts) |
| prio_reset | input | 1 | Pulse: restart the rotation once bursts drain |
| hard_reset | input | 1 | Pulse: abort and clear all state one clock later |
| halt_req | input | 1 | Debug halt request |
| free_run | input | 1 | Ignore debug halt when high |
| grant | output | 6 | One-hot grant to the active channel |
| active_code | output | 3 | Active channel code, 0 = none |
| shadow_code | output | 3 | Channel parked by a channel 1 takeover |
| hi_prio_mode | output | 1 | Current channel 1 priority mode |

## Verification
The hardest state to reach from the ports is a rotation reset that has to wait through two bursts. Getting there needs high-priority mode, a low-priority burst that is then interrupted by channel 1, and a `prio_reset` arriving while channel 1 holds the datapath. The stimulus first picks requesters so that the rotation pointer sits beyond channel 2. It then raises channel 1 together with a `word_done`, pulses `prio_reset`, and ends the two bursts one at a time. The resumed channel must reappear after the first end, and channel 2 must win after the second, where an unreset rotation would have picked channel 5.

// File: rtl/dma_arb_pkg.sv
// Package: shared types of the DMA burst arbiter.
// Assumes nothing beyond IEEE 1800-2017 enum support.
package dma_arb_pkg;

    // Progress of a deferred rotation restart.
    typedef enum logic [1:0] {
        PR_IDLE     = 2'd0,   // no restart pending
        PR_WAIT_ONE = 2'd1,   // restart at the next burst end (or at once when idle)
        PR_WAIT_TWO = 2'd2    // skip one burst end (channel 1), then wait for one more
    } prr_state_e;

endpackage

// File: rtl/dma_rr_pick.sv
// Module: dma_rr_pick
// Circular first-one search over an eligibility mask, starting at the
// entry after last_idx. Purely combinational.
// Assumes last_idx < NUM_CH.
module dma_rr_pick #(
    parameter int unsigned NUM_CH = 6,
    localparam int unsigned IDX_W = (NUM_CH > 1) ? $clog2(NUM_CH) : 1
) (
    input  logic [NUM_CH-1:0] eligible,
    input  logic [IDX_W-1:0]  last_idx,
    output logic              found,
    output logic [IDX_W-1:0]  pick_idx
);

    // Walk offsets 1..NUM_CH and keep the first eligible entry.
    always_comb begin
        found    = 1'b0;
        pick_idx = '0;
        for (int k = 1; k <= int'(NUM_CH); k++) begin
            int j;
            j = int'(last_idx) + k;
            if (j >= int'(NUM_CH)) j = j - int'(NUM_CH);
            if (!found && eligible[j]) begin
                found    = 1'b1;
                pick_idx = IDX_W'(j);
            end
        end
    end

endmodule

// File: rtl/dma_halt_gate.sv
// Module: dma_halt_gate
// Debug-halt gating. While a halt is honoured, the gate lets the current
// word finish and then stalls the grant until the halt is released.
// Assumes word_done is only meaningful while busy.
module dma_halt_gate (
    input  logic clk,
    input  logic rst_n,
    input  logic halt_req,
    input  logic free_run,
    input  logic word_done,
    input  logic busy,
    output logic hold,
    output logic stall_q
);

    // A halt counts only when free-run is off.
    always_comb hold = halt_req && !free_run;

    // Enter stall at a word boundary or when idle; leave it when the halt drops.
    always_ff @(posedge clk) begin
        if (!rst_n) stall_q <= 1'b0;
        else        stall_q <= hold && (stall_q || word_done || !busy);
    end

    // R11: a stall persists for as long as the halt is held.
    a_r11_stall_persists: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && stall_q) |=> stall_q);

endmodule

// File: rtl/dma_prr_seq.sv
// Module: dma_prr_seq
// Sequencer for the deferred rotation restart. It raises apply for one
// cycle once the bursts that must drain have ended.
// Assumes burst_end is high only while busy.
module dma_prr_seq
    import dma_arb_pkg::*;
(
    input  logic clk,
    input  logic rst_n,
    input  logic prio_reset,
    input  logic hi_mode,
    input  logic active_is_ch1,
    input  logic busy,
    input  logic burst_end,
    output logic apply
);

    prr_state_e st_q;

    // Apply when waiting for one end and the datapath is idle or just finished.
    always_comb apply = (st_q == PR_WAIT_ONE) && (!busy || burst_end);

    // Track how many burst ends are still owed before the restart.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q <= PR_IDLE;
        end else begin
            unique case (st_q)
                PR_IDLE: begin
                    if (prio_reset)
                        st_q <= (hi_mode && active_is_ch1) ? PR_WAIT_TWO : PR_WAIT_ONE;
                end
                PR_WAIT_TWO: begin
                    if (burst_end) st_q <= PR_WAIT_ONE;
                end
                PR_WAIT_ONE: begin
                    if (apply) st_q <= PR_IDLE;
                end
                default: st_q <= PR_IDLE;
            endcase
        end
    end

    // R8: a two-burst wait never applies before leaving that state.
    a_r8_two_step: assert property (@(posedge clk) disable iff (!rst_n)
        (st_q == PR_WAIT_TWO) |=> (st_q != PR_IDLE));

endmodule

// File: rtl/dma_prio_arbiter.sv
// Module: dma_prio_arbiter
// Burst arbiter for NUM_CH DMA channels: circular rotation, optional
// preemptive channel 1 with a shadow of the interrupted channel, deferred
// rotation restart, delayed hard reset and debug-halt gating.
// Assumes the datapath raises burst_done only while a channel is active,
// and that the two strobes refer to the granted channel.
module dma_prio_arbiter
    import dma_arb_pkg::*;
#(
    parameter int unsigned NUM_CH = 6,
    localparam int unsigned IDX_W  = (NUM_CH > 1) ? $clog2(NUM_CH) : 1,
    localparam int unsigned CODE_W = $clog2(NUM_CH + 1)
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic [NUM_CH-1:0] ch_enable,
    input  logic [NUM_CH-1:0] ch_request,
    input  logic              word_done,
    input  logic              burst_done,
    input  logic              cfg_wr,
    input  logic              cfg_hi_prio,
    input  logic              prio_reset,
    input  logic              hard_reset,
    input  logic              halt_req,
    input  logic              free_run,
    output logic [NUM_CH-1:0] grant,
    output logic [CODE_W-1:0] active_code,
    output logic [CODE_W-1:0] shadow_code,
    output logic              hi_prio_mode
);

    localparam logic [CODE_W-1:0] CODE_CH1   = CODE_W'(1);
    localparam logic [IDX_W-1:0]  LAST_LOW   = IDX_W'(NUM_CH - 1);
    localparam logic [IDX_W-1:0]  LAST_HIGH  = IDX_W'(0);

    logic              hr_q;
    logic              core_rst_n;
    logic [CODE_W-1:0] active_q;
    logic [CODE_W-1:0] shadow_q;
    logic [IDX_W-1:0]  last_q;
    logic              mode_q;
    logic [NUM_CH-1:0] eligible;
    logic [NUM_CH-1:0] rr_mask;
    logic              rr_found;
    logic [IDX_W-1:0]  rr_idx;
    logic              busy;
    logic              active_is_ch1;
    logic              ch1_wins;
    logic              preempt;
    logic              arb_go;
    logic              hold;
    logic              stall_q;
    logic              prr_apply;

    // Delay the hard-reset pulse one clock before it clears the core.
    always_ff @(posedge clk) begin
        if (!rst_n) hr_q <= 1'b0;
        else        hr_q <= hard_reset;
    end

    // The core is cleared by the system reset or the delayed hard reset.
    always_comb core_rst_n = rst_n && !hr_q;

    // Derive eligibility and the decisions taken this cycle.
    always_comb begin
        eligible      = ch_enable & ch_request;
        rr_mask       = eligible & ~{{(NUM_CH-1){1'b0}}, mode_q};
        busy          = (active_q != '0);
        active_is_ch1 = (active_q == CODE_CH1);
        ch1_wins      = mode_q && eligible[0];
        preempt       = mode_q && busy && !active_is_ch1 && eligible[0]
                        && word_done && !burst_done && !hold;
        arb_go        = !busy && !hold && !prr_apply;
    end

    dma_rr_pick #(.NUM_CH(NUM_CH)) u_pick (
        .eligible (rr_mask),
        .last_idx (last_q),
        .found    (rr_found),
        .pick_idx (rr_idx)
    );

    dma_halt_gate u_halt (
        .clk       (clk),
        .rst_n     (core_rst_n),
        .halt_req  (halt_req),
        .free_run  (free_run),
        .word_done (word_done),
        .busy      (busy),
        .hold      (hold),
        .stall_q   (stall_q)
    );

    dma_prr_seq u_prr (
        .clk           (clk),
        .rst_n         (core_rst_n),
        .prio_reset    (prio_reset),
        .hi_mode       (mode_q),
        .active_is_ch1 (active_is_ch1),
        .busy          (busy),
        .burst_end     (busy && burst_done),
        .apply         (prr_apply)
    );

    // Mode register: writable only while every channel is disabled.
    always_ff @(posedge clk) begin
        if (!core_rst_n)                 mode_q <= 1'b0;
        else if (cfg_wr && !(|ch_enable)) mode_q <= cfg_hi_prio;
    end

    // Rotation pointer: restarted by the sequencer, advanced by rotation picks.
    always_ff @(posedge clk) begin
        if (!core_rst_n)                 last_q <= LAST_LOW;
        else if (prr_apply)              last_q <= mode_q ? LAST_HIGH : LAST_LOW;
        else if (arb_go && !ch1_wins && rr_found) last_q <= rr_idx;
    end

    // Active and shadow codes: burst end, preemption and new grants.
    always_ff @(posedge clk) begin
        if (!core_rst_n) begin
            active_q <= '0;
            shadow_q <= '0;
        end else if (busy) begin
            if (burst_done) begin
                if (mode_q && active_is_ch1) begin
                    active_q <= shadow_q;
                end else begin
                    active_q <= '0;
                    shadow_q <= '0;
                end
            end else if (preempt) begin
                shadow_q <= active_q;
                active_q <= CODE_CH1;
            end
        end else if (arb_go) begin
            if (ch1_wins) begin
                active_q <= CODE_CH1;
                shadow_q <= '0;
            end else if (rr_found) begin
                active_q <= CODE_W'(rr_idx) + CODE_CH1;
            end
        end
    end

    // Decode the active code into a one-hot grant, masked by a halt stall.
    for (genvar i = 0; i < NUM_CH; i++) begin : g_grant
        assign grant[i] = (active_q == CODE_W'(i + 1)) && !stall_q;
    end

    assign active_code  = active_q;
    assign shadow_code  = shadow_q;
    assign hi_prio_mode = mode_q;

    // R1: the active code stays within 0..NUM_CH.
    a_r1_code_range: assert property (@(posedge clk) disable iff (!rst_n)
        active_q <= CODE_W'(NUM_CH));

    // R1: at most one grant bit.
    a_r1_grant_onehot: assert property (@(posedge clk) disable iff (!rst_n)
        $onehot0(grant));

    // R6: a takeover parks the old code and hands the datapath to channel 1.
    a_r6_shadow_capture: assert property (@(posedge clk) disable iff (!rst_n)
        (preempt && !hr_q) |=> (shadow_q == $past(active_q)) && (active_q == CODE_CH1));

    // R9: the mode holds unless written with every channel disabled.
    a_r9_mode_locked: assert property (@(posedge clk) disable iff (!rst_n)
        (!hr_q && !(cfg_wr && !(|ch_enable))) |=> $stable(mode_q));

    // R10: the delayed hard reset clears the codes and the mode.
    a_r10_hard_clear: assert property (@(posedge clk) disable iff (!rst_n)
        hr_q |=> (active_q == '0) && (shadow_q == '0) && !mode_q);

    // R11: an honoured halt keeps an idle arbiter idle.
    a_r11_no_new_grant: assert property (@(posedge clk) disable iff (!rst_n)
        (hold && !busy && !hr_q) |=> (active_q == '0));

endmodule

// File: tb/dma_prio_arbiter_bench.sv
`timescale 1ns/1ps
module dma_prio_arbiter_bench;

    localparam real HALF = 2.5;

    logic       clk = 1'b0;
    logic       rst_n;
    logic [5:0] ch_enable, ch_request;
    logic       word_done, burst_done, cfg_wr, cfg_hi_prio;
    logic       prio_reset, hard_reset, halt_req, free_run;
    logic [5:0] grant;
    logic [2:0] active_code, shadow_code;
    logic       hi_prio_mode;

    int total = 0;
    int bad   = 0;
    bit done  = 1'b0;

    always #(HALF) clk = ~clk;

    dma_prio_arbiter u_dma_prio_arbiter (
        .clk(clk), .rst_n(rst_n), .ch_enable(ch_enable), .ch_request(ch_request),
        .word_done(word_done), .burst_done(burst_done), .cfg_wr(cfg_wr),
        .cfg_hi_prio(cfg_hi_prio), .prio_reset(prio_reset), .hard_reset(hard_reset),
        .halt_req(halt_req), .free_run(free_run), .grant(grant),
        .active_code(active_code), .shadow_code(shadow_code), .hi_prio_mode(hi_prio_mode)
    );

    task automatic tick();
        @(negedge clk);
    endtask

    task automatic chk(string req, int act, int exp);
        total++;
        if (act != exp) begin
            bad++;
            $display("FAIL %s: actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    // Check active code, the matching one-hot grant and the code range (R1).
    task automatic chk_active(string req, int code);
        int g;
        g = (code == 0) ? 0 : (1 << (code - 1));
        chk({req, " active"}, active_code, code);
        chk({req, " grant"}, grant, g);
        chk("R1 code!=7", int'(active_code == 3'd7), 0);
    endtask

    task automatic pulse_bd();
        burst_done = 1'b1; tick(); burst_done = 1'b0;
    endtask

    task automatic pulse_wd();
        word_done = 1'b1; tick(); word_done = 1'b0;
    endtask

    task automatic t_reset();
        rst_n = 1'b0; ch_enable = '0; ch_request = '0; word_done = 0; burst_done = 0;
        cfg_wr = 0; cfg_hi_prio = 0; prio_reset = 0; hard_reset = 0; halt_req = 0; free_run = 0;
        repeat (3) tick();
        rst_n = 1'b1; tick();
        chk_active("R1 reset", 0);
        chk("R1 reset shadow", shadow_code, 0);
        chk("R1 reset mode", hi_prio_mode, 0);
    endtask

    // R2/R3: rotation over channels 2, 4, 6 with one idle cycle between bursts.
    task automatic t_round_robin();
        ch_enable = 6'h3F; ch_request = 6'b101010;
        tick(); chk_active("R2 first ch2", 2);
        ch_request = 6'b101011; pulse_wd(); chk_active("R3 held on word", 2);
        ch_request = 6'b101010;
        pulse_bd(); chk_active("R3 idle gap", 0);
        tick(); chk_active("R2 next ch4", 4);
        pulse_bd(); tick(); chk_active("R2 next ch6", 6);
        pulse_bd(); tick(); chk_active("R2 wrap ch2", 2);
        pulse_bd(); tick(); chk_active("R2 then ch4", 4);
    endtask

    // R4: restart deferred to the end of the ch4 burst, then from channel 1 onwards.
    task automatic t_prr_normal();
        prio_reset = 1'b1; tick(); prio_reset = 1'b0;
        chk_active("R4 deferred", 4);
        tick(); tick(); chk_active("R4 still deferred", 4);
        pulse_bd(); chk_active("R4 idle", 0);
        tick(); chk_active("R4 restart ch2", 2);
        ch_request = '0; pulse_bd(); tick(); chk_active("R4 drained", 0);
    endtask

    // R9: mode write ignored with enables set, accepted with all disabled.
    task automatic t_mode();
        cfg_hi_prio = 1'b1; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
        chk("R9 write ignored", hi_prio_mode, 0);
        ch_enable = '0; cfg_wr = 1'b1; tick(); cfg_wr = 1'b0;
        chk("R9 write taken", hi_prio_mode, 1);
        ch_enable = 6'h3F;
    endtask

    // R5/R6/R7: high-priority rotation, takeover and restore.
    task automatic t_preempt();
        prio_reset = 1'b1; tick(); prio_reset = 1'b0; tick();
        ch_request = 6'b000110; tick(); chk_active("R5 restart ch2", 2);
        ch_request = 6'b000101; tick(); chk_active("R6 waits for word", 2);
        pulse_wd(); chk_active("R6 takeover", 1);
        chk("R6 shadow", shadow_code, 2);
        ch_request = 6'b000100; tick(); chk_active("R6 ch1 held", 1);
        pulse_bd(); chk_active("R7 resume ch2", 2);
        chk("R7 shadow equal", shadow_code, 2);
        pulse_bd(); chk_active("R7 idle", 0);
        chk("R7 shadow cleared", shadow_code, 0);
        tick(); chk_active("R5 rotation ch3", 3);
        ch_request = 6'b000101; pulse_bd(); tick(); chk_active("R5 ch1 wins", 1);
        ch_request = '0; pulse_bd(); chk_active("R7 ch1 from idle", 0);
    endtask

    // R8: restart waits for the ch1 burst and the resumed ch4 burst.
    task automatic t_prr_high();
        ch_request = 6'b011010; tick(); chk_active("R8 setup ch4", 4);
        ch_request = 6'b011011; pulse_wd(); chk_active("R8 takeover", 1);
        prio_reset = 1'b1; tick(); prio_reset = 1'b0;
        ch_request = 6'b011010;
        pulse_bd(); chk_active("R8 ch4 resumes", 4);
        tick(); chk_active("R8 ch4 held", 4);
        pulse_bd(); chk_active("R8 idle", 0);
        tick(); chk_active("R8 restart ch2", 2);
        ch_request = '0; pulse_bd(); tick(); chk_active("R8 drained", 0);
    endtask

    // R11/R12: halt gating at a word boundary and while idle; free-run override.
    task automatic t_halt();
        ch_request = 6'b010000; tick(); chk_active("R11 setup ch5", 5);
        halt_req = 1'b1; tick(); chk_active("R11 word runs", 5);
        pulse_wd(); chk("R11 stalled grant", grant, 0);
        chk("R11 keeps code", active_code, 5);
        tick(); chk("R11 still stalled", grant, 0);
        halt_req = 1'b0; tick(); chk_active("R11 released", 5);
        halt_req = 1'b1; pulse_bd(); tick(); tick(); chk_active("R11 idle no grant", 0);
        halt_req = 1'b0; tick(); chk_active("R11 regrant", 5);
        free_run = 1'b1; halt_req = 1'b1; pulse_wd(); chk_active("R12 free run", 5);
        tick(); chk_active("R12 still granted", 5);
        halt_req = 1'b0; free_run = 1'b0; ch_request = '0; pulse_bd(); tick();
        chk_active("R12 drained", 0);
    endtask

    // R10: hard reset lands one edge late and clears mode and rotation.
    task automatic t_hard();
        ch_request = 6'b000010; tick(); chk_active("R10 setup ch2", 2);
        ch_request = '0; hard_reset = 1'b1; tick(); hard_reset = 1'b0;
        chk_active("R10 one-clock delay", 2);
        tick(); chk_active("R10 cleared", 0);
        chk("R10 mode cleared", hi_prio_mode, 0);
        chk("R10 shadow cleared", shadow_code, 0);
        ch_request = 6'b000101; tick(); chk_active("R10 rotation from ch1", 1);
        ch_request = '0; pulse_bd(); tick();
    endtask

    initial begin
        t_reset();
        t_round_robin();
        t_prr_normal();
        t_mode();
        t_preempt();
        t_prr_high();
        t_halt();
        t_hard();
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        #(HALF * 2.0 * 20000.0);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog: actual=running expected=finished");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

endmodule